// File: doc/BRIEF.md
# Programmable-Window Input Deglitcher

This block cleans up one synchronized input line before the line's level is stored or used to raise interrupts. A new level on the raw input is taken only after the input has held that level, without a break, for a window that software sets. The window is `cfg_cnt × 2^cfg_sel` clock periods. A 4-bit count sets the number of prescaler ticks, and a 4-bit select sets the tick period as a power of two. The longest window is 15 × 2^15 = 491,520 clocks. With a 2.5 ns filter clock, the usual setting of count 9 and select 4 gives 144 clocks, which is 360 ns.

The design is a two-state machine with two counters. In **ST_IDLE** the filtered output agrees with the raw input, or filtering is off. In **ST_QUAL** the raw input disagrees with the output and the input is being timed. The transitions are:
- **start**: ST_IDLE to ST_QUAL, when the raw input differs from the output and the count is non-zero.
- **abort**: ST_QUAL to ST_IDLE, when the raw input returns to the output level.
- **accept**: ST_QUAL to ST_IDLE, when the window completes. The output takes the raw level.
- **restart**: any state to ST_IDLE, when the configuration changes. The output is held.
- **pass**: ST_IDLE to ST_IDLE, when the count is zero. The output copies the raw input.

A prescaler gives one tick every `2^cfg_sel` clocks while the machine is in ST_QUAL. The stability counter advances only on those ticks. Both counters clear whenever the machine is not qualifying.

Top module: `deglitch_window`

## Requirements
- R1: During and after an asynchronous reset (rst_n low), filt_out is 0 and no qualification is in progress.
- R2: With cfg_cnt ≠ 0 and N = cfg_cnt × 2^cfg_sel, a raw level that differs from filt_out and is sampled unchanged on N+1 consecutive rising edges appears on filt_out right after the (N+1)th edge.
- R3: A differing raw level that is held for N or fewer consecutive edges never reaches filt_out.
- R4: With cfg_cnt = 0, including the all-zero configuration, filt_out copies the raw level sampled at each rising edge. The output therefore lags by one clock.
- R5: While qualifying, the stability counter advances once per 2^cfg_sel clocks and at no other time. This holds for every select value up to 15.
- R6: A raw input that returns to the filt_out level during qualification discards all progress. The next differing level needs a full N+1 edges again.
- R7: An edge at which {cfg_cnt, cfg_sel} differs from its value at the previous edge leaves filt_out unchanged and restarts qualification. Qualification counts from the following edge, so a level present through the change needs N+2 edges.
- R8: filt_out only ever changes to the raw level sampled at the edge of the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_in | input | 1 | Synchronized raw pin level |
| cfg_cnt | input | 4 | Window length, in prescaler ticks (0 = no filtering) |
| cfg_sel | input | 4 | Prescaler select; a tick every 2^cfg_sel clocks |
| filt_out | output | 1 | Filtered level |

## Verification
Several properties are checked on every cycle:
- A configuration change never moves the output.
- A raw return during ST_QUAL always aborts to ST_IDLE with the output held.
- The zero-count path copies the input one clock later.
- Every output change carries the level sampled at that edge.
- The stability counter never moves between ticks.

Only the bench scenarios can show the exact window lengths. They confirm that a level held for N edges is rejected and one held for N+1 edges is accepted, across several count and select pairs, the 144-clock default and the full 2^15 prescale. They also show the one-edge delay that follows a configuration change.

// File: rtl/dgw_pkg.sv
package dgw_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_QUAL = 1'b1
    } dgw_state_e;

endpackage

// File: rtl/dgw_prescale.sv
module dgw_prescale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = (PRE_W'(1) << sel) - PRE_W'(1);
        tick = run && ((pcnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clear) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= tick ? '0 : pcnt_q + PRE_W'(1);
        end
    end

    // R6: a cleared prescaler restarts from zero
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pcnt_q == '0));

endmodule

// File: rtl/dgw_stab_count.sv
module dgw_stab_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    output logic             done
);
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    logic [CNT_W-1:0] scnt_q;
    logic [CNT_W:0]   scnt_inc;

    always_comb begin
        scnt_inc = {1'b0, scnt_q} + ONE;
        done     = tick && (scnt_inc == {1'b0, cnt});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
        end else if (clear) begin
            scnt_q <= '0;
        end else if (tick) begin
            scnt_q <= scnt_inc[CNT_W-1:0];
        end
    end

    // R5: the stability count moves only on prescaler ticks
    p_tick_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(scnt_q));

endmodule

// File: rtl/deglitch_window.sv
module deglitch_window #(
    parameter int CNT_W = 4,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_in,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             filt_out
);
    import dgw_pkg::*;

    localparam int CFG_W = CNT_W + SEL_W;

    dgw_state_e       state_q, state_n;
    logic             filt_q, filt_n;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;
    logic             differ;
    logic             run, clr;
    logic             tick, done;

    always_comb begin
        cfg_chg = ({cfg_cnt, cfg_sel} != cfg_q);
        differ  = (raw_in != filt_q);
        run     = (state_q == ST_QUAL) && !cfg_chg && differ;
        clr     = !run;
    end

    dgw_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr),
        .run   (run),
        .sel   (cfg_sel),
        .tick  (tick)
    );

    dgw_stab_count #(.CNT_W(CNT_W)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr),
        .tick  (tick),
        .cnt   (cfg_cnt),
        .done  (done)
    );

    // next state and next output
    always_comb begin
        state_n = state_q;
        filt_n  = filt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_chg) begin
                    state_n = ST_IDLE;               // restart
                end else if (differ) begin
                    if (cfg_cnt == '0) begin
                        filt_n = raw_in;             // pass
                    end else begin
                        state_n = ST_QUAL;           // start
                    end
                end
            end
            ST_QUAL: begin
                if (cfg_chg) begin
                    state_n = ST_IDLE;               // restart
                end else if (!differ) begin
                    state_n = ST_IDLE;               // abort
                end else if (done) begin
                    state_n = ST_IDLE;               // accept
                    filt_n  = raw_in;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_n;
            cfg_q   <= {cfg_cnt, cfg_sel};
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
        end else begin
            filt_q <= filt_n;
        end
    end

    assign filt_out = filt_q;

    // R7: a configuration change never moves the output
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> $stable(filt_out));

    // R6: raw input returning during qualification aborts with output held
    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL && !differ && !cfg_chg) |=> (state_q == ST_IDLE && $stable(filt_out)));

    // R4: zero count copies the raw level one clock later
    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cfg_cnt == '0 && !cfg_chg) |=> (filt_out == $past(raw_in)));

    // R8: every output change carries the sampled raw level
    p_src_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_out) |-> (filt_out == $past(raw_in)));

endmodule

// File: tb/deglitch_window_test.sv
`timescale 1ns/1ps
module deglitch_window_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_in = 1'b0;
    logic [3:0] cfg_cnt = 4'd2;
    logic [3:0] cfg_sel = 4'd1;
    logic       filt_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    deglitch_window uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw_in),
        .cfg_cnt  (cfg_cnt),
        .cfg_sel  (cfg_sel),
        .filt_out (filt_out)
    );

    typedef struct packed {
        logic [3:0]  cnt;
        logic [3:0]  sel;
        logic        raw;
        logic [31:0] hold;
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  4'd1,  1'b1, 32'd4,     1'b0, 8'd3},  // R3: N=4, 4 edges rejected
        '{4'd2,  4'd1,  1'b0, 32'd3,     1'b0, 8'd6},  // R6: glitch gone
        '{4'd2,  4'd1,  1'b1, 32'd5,     1'b1, 8'd2},  // R2: 5 edges accepted
        '{4'd2,  4'd1,  1'b1, 32'd3,     1'b1, 8'd2},  // R2: steady
        '{4'd2,  4'd1,  1'b0, 32'd4,     1'b1, 8'd3},  // R3
        '{4'd2,  4'd1,  1'b0, 32'd1,     1'b0, 8'd2},  // R2: total 5
        '{4'd3,  4'd0,  1'b1, 32'd4,     1'b0, 8'd7},  // R7: change costs one edge
        '{4'd3,  4'd0,  1'b1, 32'd1,     1'b1, 8'd7},  // R7
        '{4'd0,  4'd0,  1'b0, 32'd1,     1'b1, 8'd7},  // R7: held at change edge
        '{4'd0,  4'd0,  1'b0, 32'd1,     1'b0, 8'd4},  // R4
        '{4'd0,  4'd0,  1'b1, 32'd1,     1'b1, 8'd4},  // R4
        '{4'd0,  4'd0,  1'b0, 32'd1,     1'b0, 8'd4},  // R4
        '{4'd9,  4'd4,  1'b1, 32'd145,   1'b0, 8'd3},  // R3: default window
        '{4'd9,  4'd4,  1'b1, 32'd1,     1'b1, 8'd2},  // R2
        '{4'd9,  4'd4,  1'b0, 32'd144,   1'b1, 8'd3},  // R3
        '{4'd9,  4'd4,  1'b0, 32'd1,     1'b0, 8'd2},  // R2
        '{4'd1,  4'd15, 1'b1, 32'd32769, 1'b0, 8'd5},  // R5: 2^15 prescale
        '{4'd1,  4'd15, 1'b1, 32'd1,     1'b1, 8'd5},  // R5
        '{4'd15, 4'd3,  1'b0, 32'd121,   1'b1, 8'd5},  // R5: count 15
        '{4'd15, 4'd3,  1'b0, 32'd1,     1'b0, 8'd2}   // R2
    };

    task automatic check(input logic act, input logic exp, input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: filt_out=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state with raw held high
        raw_in = 1'b1;
        #1;
        check(filt_out, 1'b0, 1, "during reset");
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        raw_in = 1'b0;
        repeat (5) @(negedge clk);
        check(filt_out, 1'b0, 1, "after reset");

        for (int i = 0; i < NV; i++) begin
            cfg_cnt = VEC[i].cnt;
            cfg_sel = VEC[i].sel;
            raw_in  = VEC[i].raw;
            repeat (VEC[i].hold) @(posedge clk);
            @(negedge clk);
            check(filt_out, VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
        end

        // R6: partial progress discarded; N=4, 3 edges, back, then 4 edges
        cfg_cnt = 4'd2; cfg_sel = 4'd1; raw_in = 1'b0;
        repeat (3) @(negedge clk);
        raw_in = 1'b1;
        repeat (3) @(negedge clk);
        raw_in = 1'b0;
        @(negedge clk);
        raw_in = 1'b1;
        repeat (4) @(negedge clk);
        check(filt_out, 1'b0, 6, "no carried progress");
        @(negedge clk);
        check(filt_out, 1'b1, 6, "full window after abort");

        // R1: asynchronous reset clears an accepted high level
        rst_n = 1'b0;
        #1;
        check(filt_out, 1'b0, 1, "async reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(filt_out, 1'b0, 1, "first edge after reset");

        finish_run();
    end

endmodule